// File: doc/BRIEF.md
# Floating-Point Coprocessor Instruction Decoder

This block classifies floating-point coprocessor instructions for a front end that emulates or dispatches them. It takes three 16-bit words: the opcode word, the first extension word, and an optional second extension word. From these it produces a single operation class, an illegal-encoding flag, the arithmetic operation code with its modifiers, a flag that tells the back end to drop the result, the instruction length in bytes, and a signed 32-bit displacement for branch-like instructions.

The decoding is combinational. The results are captured in one register stage on the cycle that `valid_i` is high, and they stay unchanged until the next strobe. When an encoding is rejected, every class output is forced to zero and only the illegal flag is set. The block does not compute effective addresses, fetch operands, do arithmetic, or save and restore state.

Class codes on `kind_o`:

| Code | Class |
|---|---|
| 0 | none |
| 1 | data-register multiple move |
| 2 | control-register multiple move |
| 3 | store to memory |
| 4 | constant load |
| 5 | scale |
| 6 | arithmetic |
| 7 | set on condition |
| 8 | decrement and branch |
| 9 | trap on condition |
| 10 | conditional branch |

Top module: `fpcp_decoder`

## Requirements
- R1: An instruction is illegal unless opcode bits [15:12] are 1111 and opcode bits [11:9] are 001.
- R2: Opcode bits [8:6] select the group. The groups are:
  - 000: general.
  - 001: conditional set, decrement-branch and trap.
  - 010: branch with a short displacement.
  - 011: branch with a long displacement.
  - 100 to 111: illegal.
- R3: In the general group, extension bit 15 set means a multiple move. Extension bit 14 = 1 gives class 1 and bit 14 = 0 gives class 2. The length is 4.
- R4: In the general group with extension bit 15 clear, the first matching rule wins, in this order:
  - (ext & 0xE000) == 0x6000 gives class 3.
  - (ext & 0xFC00) == 0x5C00 gives class 4.
  - (ext & 0xA07F) == 0x0026 gives class 5.
  - Anything else gives class 6. All of these have length 4.
- R5: For class 6, extension bits [6:0] are the operation code.
  - The legal codes are 0x00 to 0x04, 0x06, 0x08 to 0x0A, 0x0C to 0x12, 0x14 to 0x16, 0x18 to 0x1A, 0x1C to 0x25, 0x27, 0x28, 0x30 to 0x38, and 0x3A. Every other code is illegal.
  - Code 0x28 is reported as `op_o` = 0x22 with `neg_o` = 1.
  - Codes 0x30 to 0x37 are reported as 0x30, with `aux_o` set to extension bits [2:0].
  - Every other legal code is reported unchanged, with `aux_o` = 0.
- R6: `discard_o` is 1 exactly for arithmetic codes 0x38 and 0x3A.
- R7: A short branch has length 4 and a displacement equal to the first extension word sign-extended. A long branch has length 6 and a displacement of {ext1, ext2}.
- R8: In group 001, the mode field is opcode bits [5:3].
  - Mode 001 is decrement-and-branch: length 6, displacement equal to the second extension word sign-extended.
  - Mode 111 with opcode bits [2:0] equal to 2, 3 or 4 is a trap, with length 6, 8 or 4 respectively.
  - Mode 111 with opcode bits [2:0] equal to 5, 6 or 7 is illegal.
  - Every other mode and low-bit combination is set-on-condition with length 4.
- R9: When `illegal_o` = 1, `kind_o`, `op_o`, `neg_o`, `discard_o`, `aux_o`, `len_o` and `disp_o` are all 0.
- R10: Outputs are updated on the first rising clock edge at which `valid_i` is 1. Otherwise they hold their values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for the input words |
| opcode_i | input | 16 | Opcode word |
| ext1_i | input | 16 | First extension word |
| ext2_i | input | 16 | Second extension word |
| kind_o | output | 4 | Operation class code |
| illegal_o | output | 1 | Illegal encoding |
| op_o | output | 7 | Normalised arithmetic operation code |
| neg_o | output | 1 | Negate the second operand |
| discard_o | output | 1 | Drop the arithmetic result |
| aux_o | output | 3 | Cosine destination register for the combined sine/cosine operation |
| len_o | output | 4 | Instruction length in bytes |
| disp_o | output | 32 | Signed displacement |

## Verification
Some cases are hard to reach from the ports. The first is the boundary between the scale pattern and an arithmetic code of 0x26 with extension bit 13 set, which is rejected as illegal. The second is the trap-length subcases, which only exist when a valid header, group 001 and mode 111 all occur together. Fully random words almost never reach these. The stimulus therefore usually forces a legal header, picks the group and mode fields from a weighted draw, and builds extension words around the mask patterns. Directed vectors cover each pattern edge and each low-bit value of the trap mode.

// File: rtl/fpcp_decoder_pkg.sv
package fpcp_decoder_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OP_W   = 7;
  localparam int unsigned LEN_W  = 4;
  localparam int unsigned DISP_W = 32;

  typedef enum logic [3:0] {
    K_NONE      = 4'd0,
    K_MOVE_DATA = 4'd1,
    K_MOVE_CTRL = 4'd2,
    K_STORE     = 4'd3,
    K_CONST     = 4'd4,
    K_SCALE     = 4'd5,
    K_ARITH     = 4'd6,
    K_SETCC     = 4'd7,
    K_DECBR     = 4'd8,
    K_TRAP      = 4'd9,
    K_BRANCH    = 4'd10
  } kind_e;

  localparam logic [OP_W-1:0] OP_ADD    = 7'h22;
  localparam logic [OP_W-1:0] OP_SUB    = 7'h28;
  localparam logic [OP_W-1:0] OP_SINCOS = 7'h30;
  localparam logic [OP_W-1:0] OP_CMP    = 7'h38;
  localparam logic [OP_W-1:0] OP_TST    = 7'h3A;

  typedef struct packed {
    kind_e             kind;
    logic              illegal;
    logic [OP_W-1:0]   op;
    logic              neg;
    logic              discard;
    logic [2:0]        aux;
    logic [LEN_W-1:0]  len;
    logic [DISP_W-1:0] disp;
  } dec_t;

  function automatic logic [DISP_W-1:0] sext16(input logic [WORD_W-1:0] w);
    return {{(DISP_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction
endpackage

// File: rtl/fpcp_arith_map.sv
module fpcp_arith_map
  import fpcp_decoder_pkg::*;
(
  input  logic [OP_W-1:0] code_i,
  output logic            legal_o,
  output logic [OP_W-1:0] op_o,
  output logic            neg_o,
  output logic            discard_o,
  output logic [2:0]      aux_o
);
  always_comb begin
    legal_o   = 1'b1;
    op_o      = code_i;
    neg_o     = 1'b0;
    discard_o = 1'b0;
    aux_o     = 3'd0;
    case (code_i) inside
      7'h05, 7'h07, 7'h0B, 7'h13, 7'h17, 7'h1B, 7'h26, 7'h29, 7'h39,
      [7'h2A:7'h2F], [7'h3B:7'h7F]: legal_o = 1'b0;
      OP_SUB: begin
        op_o  = OP_ADD;
        neg_o = 1'b1;
      end
      [7'h30:7'h37]: begin
        op_o  = OP_SINCOS;
        aux_o = code_i[2:0];
      end
      OP_CMP, OP_TST: discard_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/fpcp_gen_dec.sv
module fpcp_gen_dec
  import fpcp_decoder_pkg::*;
(
  input  logic [WORD_W-1:0] ext1_i,
  output dec_t              dec_o
);
  logic            a_legal;
  logic [OP_W-1:0] a_op;
  logic            a_neg;
  logic            a_disc;
  logic [2:0]      a_aux;

  fpcp_arith_map i_arith (
    .code_i   (ext1_i[OP_W-1:0]),
    .legal_o  (a_legal),
    .op_o     (a_op),
    .neg_o    (a_neg),
    .discard_o(a_disc),
    .aux_o    (a_aux)
  );

  always_comb begin
    dec_o     = '0;
    dec_o.len = LEN_W'(4);
    if (ext1_i[15]) begin
      dec_o.kind = ext1_i[14] ? K_MOVE_DATA : K_MOVE_CTRL;
    end else if ((ext1_i & 16'hE000) == 16'h6000) begin
      dec_o.kind = K_STORE;
    end else if ((ext1_i & 16'hFC00) == 16'h5C00) begin
      dec_o.kind = K_CONST;
    end else if ((ext1_i & 16'hA07F) == 16'h0026) begin
      dec_o.kind = K_SCALE;
    end else begin
      dec_o.kind    = K_ARITH;
      dec_o.illegal = !a_legal;
      dec_o.op      = a_op;
      dec_o.neg     = a_neg;
      dec_o.discard = a_disc;
      dec_o.aux     = a_aux;
    end
  end
endmodule

// File: rtl/fpcp_cond_dec.sv
module fpcp_cond_dec
  import fpcp_decoder_pkg::*;
(
  input  logic [5:0]        mode_i,
  input  logic [WORD_W-1:0] ext2_i,
  output dec_t              dec_o
);
  logic [2:0] mode;
  logic [2:0] low;
  assign mode = mode_i[5:3];
  assign low  = mode_i[2:0];

  always_comb begin
    dec_o      = '0;
    dec_o.kind = K_SETCC;
    dec_o.len  = LEN_W'(4);
    if (mode == 3'b001) begin
      dec_o.kind = K_DECBR;
      dec_o.len  = LEN_W'(6);
      dec_o.disp = sext16(ext2_i);
    end else if (mode == 3'b111 && low >= 3'd2) begin
      dec_o.kind = K_TRAP;
      case (low)
        3'd2:    dec_o.len = LEN_W'(6);
        3'd3:    dec_o.len = LEN_W'(8);
        3'd4:    dec_o.len = LEN_W'(4);
        default: dec_o.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fpcp_decoder.sv
module fpcp_decoder
  import fpcp_decoder_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] opcode_i,
  input  logic [WORD_W-1:0] ext1_i,
  input  logic [WORD_W-1:0] ext2_i,
  output logic [3:0]        kind_o,
  output logic              illegal_o,
  output logic [OP_W-1:0]   op_o,
  output logic              neg_o,
  output logic              discard_o,
  output logic [2:0]        aux_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DISP_W-1:0] disp_o
);
  dec_t gen_d, cond_d, br_d, sel_d, q;
  logic hdr_ok;

  fpcp_gen_dec i_gen (
    .ext1_i(ext1_i),
    .dec_o (gen_d)
  );

  fpcp_cond_dec i_cond (
    .mode_i(opcode_i[5:0]),
    .ext2_i(ext2_i),
    .dec_o (cond_d)
  );

  // branch: bit 6 picks long displacement
  always_comb begin
    br_d      = '0;
    br_d.kind = K_BRANCH;
    if (opcode_i[6]) begin
      br_d.len  = LEN_W'(6);
      br_d.disp = {ext1_i, ext2_i};
    end else begin
      br_d.len  = LEN_W'(4);
      br_d.disp = sext16(ext1_i);
    end
  end

  assign hdr_ok = (opcode_i[15:12] == 4'hF) && (opcode_i[11:9] == 3'b001);

  always_comb begin
    case (opcode_i[8:6])
      3'b000:         sel_d = gen_d;
      3'b001:         sel_d = cond_d;
      3'b010, 3'b011: sel_d = br_d;
      default: begin
        sel_d         = '0;
        sel_d.illegal = 1'b1;
      end
    endcase
    if (!hdr_ok) sel_d.illegal = 1'b1;
    if (sel_d.illegal) begin
      sel_d         = '0;
      sel_d.illegal = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (valid_i) q <= sel_d;
  end

  assign kind_o    = q.kind;
  assign illegal_o = q.illegal;
  assign op_o      = q.op;
  assign neg_o     = q.neg;
  assign discard_o = q.discard;
  assign aux_o     = q.aux;
  assign len_o     = q.len;
  assign disp_o    = q.disp;

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(kind_o) && $stable(illegal_o) && $stable(len_o) && $stable(disp_o));
  // R9
  neutral_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> kind_o == 4'd0 && op_o == '0 && len_o == '0 && disp_o == '0 && !discard_o);
  // R1
  hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[15:12] != 4'hF |=> illegal_o);
  // R6
  discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> kind_o == 4'd6 && (op_o == OP_CMP || op_o == OP_TST));
  // R5
  neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_o |-> kind_o == 4'd6 && op_o == OP_ADD);
  // R7
  long_br_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[15:6] == 10'b1111_001_011 |=>
      kind_o == 4'd10 && len_o == 4'd6 && disp_o == $past({ext1_i, ext2_i}));
endmodule

// File: tb/test_fpcp_decoder.sv
module test_fpcp_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] opc = '0, w1 = '0, w2 = '0;
  logic [3:0]  kind;
  logic        ill, neg, disc;
  logic [6:0]  op;
  logic [2:0]  aux;
  logic [3:0]  len;
  logic [31:0] disp;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fpcp_decoder i_fpcp_decoder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opc), .ext1_i(w1), .ext2_i(w2),
    .kind_o(kind), .illegal_o(ill), .op_o(op), .neg_o(neg), .discard_o(disc), .aux_o(aux),
    .len_o(len), .disp_o(disp)
  );

  function automatic logic [52:0] actual();
    return {kind, ill, op, neg, disc, aux, len, disp};
  endfunction

  function automatic bit arith_ok(input logic [6:0] c);
    if (c > 7'h3A) return 0;
    if (c == 7'h26 || c == 7'h39) return 0;
    if (c >= 7'h29 && c <= 7'h2F) return 0;
    if (c < 7'h20 && (c[1:0] == 2'b11) && c[2] == 1'b1 && c != 7'h0F && c != 7'h1F) return 0;
    if (c == 7'h05 || c == 7'h0B || c == 7'h13 || c == 7'h1B) return 0;
    return 1;
  endfunction

  function automatic logic [52:0] model(input logic [15:0] o, input logic [15:0] a, input logic [15:0] b);
    logic [3:0] k = 0; logic bad = 0; logic [6:0] p = 0; logic n = 0, d = 0;
    logic [2:0] x = 0; logic [3:0] l = 4; logic [31:0] s = 0;
    if (o[15:9] != 7'b1111001 || o[8]) bad = 1;
    else if (o[8:7] == 2'b01) begin
      k = 10;
      if (o[6]) begin l = 6; s = {a, b}; end
      else s = {{16{a[15]}}, a};
    end else if (o[6]) begin
      k = 7;
      if (o[5:3] == 3'b001) begin k = 8; l = 6; s = {{16{b[15]}}, b}; end
      else if (o[5:3] == 3'b111 && o[2:0] > 1) begin
        k = 9;
        if (o[2:0] == 2) l = 6; else if (o[2:0] == 3) l = 8; else if (o[2:0] == 4) l = 4; else bad = 1;
      end
    end else if (a[15]) k = a[14] ? 1 : 2;
    else if (a[14:13] == 2'b11) k = 3;
    else if (a[14:10] == 5'b10111) k = 4;
    else if (!a[13] && a[6:0] == 7'h26) k = 5;
    else begin
      k = 6;
      if (!arith_ok(a[6:0])) bad = 1;
      p = a[6:0];
      if (p == 7'h28) begin p = 7'h22; n = 1; end
      if (p[6:3] == 4'b0110) begin x = p[2:0]; p = 7'h30; end
      d = (p == 7'h38 || p == 7'h3A);
    end
    if (bad) return {4'd0, 1'b1, 48'd0};
    return {k, 1'b0, p, n, d, x, l, s};
  endfunction

  task automatic check(input string tag, input logic [52:0] exp);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s: opc=%h w1=%h w2=%h actual=%h expected=%h", tag, opc, w1, w2, actual(), exp);
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] o, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    opc = o; w1 = a; w2 = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check(tag, model(o, a, b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [52:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10 reset", 53'd0);
    rst_n = 1'b1;
    // R1 header
    apply("R1", 16'hE200, 16'h0000, 0);
    apply("R1", 16'hF400, 16'h0000, 0);
    apply("R1", 16'h7200, 16'h0022, 0);
    // R2 groups
    for (int t = 0; t < 8; t++) apply("R2", 16'hF200 | 16'(t << 6), 16'h0022, 16'h1234);
    // R3
    apply("R3", 16'hF200, 16'hC000, 0);
    apply("R3", 16'hF200, 16'h8000, 0);
    // R4 patterns and edges
    apply("R4", 16'hF200, 16'h6000, 0);
    apply("R4", 16'hF200, 16'h7C00, 0);
    apply("R4", 16'hF200, 16'h5C00, 0);
    apply("R4", 16'hF200, 16'h5800, 0);
    apply("R4", 16'hF200, 16'h0026, 0);
    apply("R4", 16'hF200, 16'h5FA6, 0);
    apply("R4", 16'hF200, 16'h2026, 0);
    apply("R4", 16'hF200, 16'h4026, 0);
    // R5 / R6
    apply("R5", 16'hF200, 16'h0028, 0);
    apply("R5", 16'hF200, 16'h0033, 0);
    apply("R5", 16'hF200, 16'h0005, 0);
    apply("R5", 16'hF200, 16'h0040, 0);
    apply("R6", 16'hF200, 16'h0038, 0);
    apply("R6", 16'hF200, 16'h003A, 0);
    apply("R6", 16'hF200, 16'h0039, 0);
    // R7
    apply("R7", 16'hF280, 16'hFFF0, 16'h5555);
    apply("R7", 16'hF2C0, 16'h8001, 16'h00FE);
    // R8 trap mode low values and decrement-branch
    for (int l = 0; l < 8; l++) apply("R8", 16'hF278 | 16'(l), 16'h0003, 16'h9000);
    apply("R8", 16'hF24A, 16'h0001, 16'h8002);
    // R9 illegal after a populated result
    apply("R9", 16'hF2C0, 16'h1234, 16'h5678);
    apply("R9", 16'hF300, 16'h1234, 16'h5678);
    // R10 hold without strobe
    apply("R10", 16'hF2C0, 16'hABCD, 16'h0123);
    held = actual();
    @(negedge clk); opc = 16'hF200; w1 = 16'h0038; w2 = 0;
    @(negedge clk); @(negedge clk);
    check("R10 hold", held);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] o, a;
      o = 16'($urandom);
      if (($urandom % 8) != 0) o[15:9] = 7'b1111001;
      if (($urandom % 2) != 0) o[8:6] = 3'($urandom % 4);
      if (($urandom % 3) == 0) o[5:3] = 3'b111;
      a = 16'($urandom);
      case ($urandom % 4)
        0: a[15] = 1'b0;
        1: a = {1'b0, a[14:7], 7'($urandom % 64)};
        2: a = {2'b01, 1'($urandom), 2'b11, a[10:7], 7'h26};
        default: ;
      endcase
      apply("R2 random", o, a, 16'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule